// File: doc/BRIEF.md
# Exposed-Latency Result Commit Pipeline

This block is the result-commit stage of a statically scheduled in-order core that has no hazard interlocks. Each accepted operation brings a destination register index, an already computed result and an operation class. The class sets a fixed number of cycles before the result lands in the register file. Until that landing, every read of the destination returns its previous contents. The compiler is expected to know these latencies and to schedule each consumer after the producer's result becomes visible.

Each class has its own delay line. All lines drain into one common commit stage, so the register file has a single write port. Load results are not taken from the issue port. They come from a completion input in the cycle the load reaches the commit stage, and a hit flag on that input says whether the data is ready. A miss stops the pipeline until the data comes back. The operation that follows the load is then accepted only after the new value has been written.

Top module: `exlat_wb_pipe`

## Requirements
- R1: A synchronous active-high reset sets every register to zero, drops every in-flight operation, and clears both `stall` and `sched_err`.
- R2: Register index 0 always reads as zero. Writes that target it are discarded.
- R3: An operation of class code 0 (ALU, latency 1) issued in cycle t is not visible in cycle t and is readable from cycle t+1.
- R4: An operation of class code 2 (multiply, latency 3) issued in cycle t leaves its destination unchanged in cycles t+1 and t+2. The new value is readable from cycle t+3.
- R5: A load (class code 1, latency 2) whose hit flag is high in cycle t+1 commits the `ld_data` presented in that cycle. Reads in cycle t+1 return the old value and reads from cycle t+2 return the new one. The issue data of a load is ignored.
- R6: If the hit flag is low when a load reaches the commit stage, `stall` is high in that cycle. It stays high through the cycle in which the hit flag rises, and the load commits the `ld_data` of that cycle. In the following cycle `stall` is low and reads return the new value.
- R7: While `stall` is high, issue is ignored and no register changes except for the returning load.
- R8: If two in-flight operations reach the commit stage in the same cycle, the one issued earlier (longer latency) is written and the other is dropped. `sched_err` then rises and stays high until reset. A load that loses this way never stalls.
- R9: An issue carrying class code 3 is discarded.
- R10: Both read ports are combinational, independent, and show register-file contents only, with no forwarding from in-flight operations.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| iss_valid | input | 1 | Operation offered this cycle |
| iss_class | input | 2 | Class: 0 ALU, 1 load, 2 multiply, 3 none |
| iss_dest | input | AW | Destination register index |
| iss_data | input | DW | Precomputed result (ignored for loads) |
| ld_hit | input | 1 | Load data ready at the commit stage |
| ld_data | input | DW | Load data, taken when `ld_hit` is high |
| rd_addr_a | input | AW | Read port A index |
| rd_data_a | output | DW | Read port A data |
| rd_addr_b | input | AW | Read port B index |
| rd_data_b | output | DW | Read port B data |
| stall | output | 1 | Issue is refused this cycle |
| sched_err | output | 1 | Sticky commit-collision flag |

## Verification
A multiply issued two cycles before an ALU operation, or one cycle before a load, reaches the commit stage in the same cycle as the later operation. The bench provokes this collision on purpose and also lets random issue streams fall into it. The judgement is that only the older result lands, `sched_err` rises on that edge, and a losing load with a low hit flag raises no stall. A second overlap is a load miss ending while issue is still being offered. There the bench checks that nothing offered during the stall reaches the register file.

// File: rtl/exlat_pkg.sv
package exlat_pkg;

   typedef enum logic [1:0] {
      OP_ALU  = 2'd0,
      OP_LOAD = 2'd1,
      OP_MUL  = 2'd2,
      OP_NONE = 2'd3
   } op_class_e;

   localparam int NUM_CLASS = 3;

   // latency of class c, given the three per-class latencies
   function automatic int class_lat(input int c, input int la, input int ll, input int lm);
      case (c)
         0:       return la;
         1:       return ll;
         default: return lm;
      endcase
   endfunction

endpackage

// File: rtl/exlat_delay_line.sv
module exlat_delay_line #(
   parameter int LAT = 1,
   parameter int AW  = 4,
   parameter int DW  = 32
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          adv,
   input  logic          in_v,
   input  logic [AW-1:0] in_dest,
   input  logic [DW-1:0] in_data,
   output logic          hd_v,
   output logic [AW-1:0] hd_dest,
   output logic [DW-1:0] hd_data
);

   if (LAT < 1) begin : g_bad_lat
      $error("exlat_delay_line: LAT must be at least 1");
   end

   if (LAT == 1) begin : g_direct
      logic unused_ctl;
      assign unused_ctl = ^{clk, rst, adv};
      assign hd_v    = in_v;
      assign hd_dest = in_dest;
      assign hd_data = in_data;
   end else begin : g_pipe
      localparam int NST = LAT - 1;
      logic [NST-1:0]         v_q;
      logic [NST-1:0][AW-1:0] d_q;
      logic [NST-1:0][DW-1:0] x_q;

      always_ff @(posedge clk) begin
         if (rst) begin
            v_q <= '0;
         end else if (adv) begin
            v_q[0] <= in_v;
            for (int k = 1; k < NST; k++) v_q[k] <= v_q[k-1];
         end
      end

      always_ff @(posedge clk) begin
         if (adv) begin
            d_q[0] <= in_dest;
            x_q[0] <= in_data;
            for (int k = 1; k < NST; k++) begin
               d_q[k] <= d_q[k-1];
               x_q[k] <= x_q[k-1];
            end
         end
      end

      assign hd_v    = v_q[NST-1];
      assign hd_dest = d_q[NST-1];
      assign hd_data = x_q[NST-1];
   end

endmodule

// File: rtl/exlat_commit_arb.sv
module exlat_commit_arb #(
   parameter int NC = 3,
   parameter int AW = 4,
   parameter int DW = 32
) (
   input  logic [NC-1:0]         hv,
   input  logic [NC-1:0][AW-1:0] hd,
   input  logic [NC-1:0][DW-1:0] hx,
   output logic                  wv,
   output logic [AW-1:0]         wd,
   output logic [DW-1:0]         wx,
   output logic                  clash
);

   // higher index = longer latency = issued earlier, so it overrides
   always_comb begin
      wv = 1'b0;
      wd = '0;
      wx = '0;
      for (int c = 0; c < NC; c++) begin
         if (hv[c]) begin
            wv = 1'b1;
            wd = hd[c];
            wx = hx[c];
         end
      end
   end

   assign clash = |(hv & (hv - NC'(1)));

endmodule

// File: rtl/exlat_regfile.sv
module exlat_regfile #(
   parameter int NREG = 16,
   parameter int AW   = 4,
   parameter int DW   = 32
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          we,
   input  logic [AW-1:0] wa,
   input  logic [DW-1:0] wd,
   input  logic [AW-1:0] ra0,
   output logic [DW-1:0] rd0,
   input  logic [AW-1:0] ra1,
   output logic [DW-1:0] rd1
);

   logic [DW-1:0] mem [NREG];

   always_ff @(posedge clk) begin
      if (rst) begin
         for (int i = 0; i < NREG; i++) mem[i] <= '0;
      end else if (we && (wa != '0)) begin
         mem[wa] <= wd;
      end
   end

   assign rd0 = (ra0 == '0) ? '0 : mem[ra0];
   assign rd1 = (ra1 == '0) ? '0 : mem[ra1];

endmodule

// File: rtl/exlat_wb_pipe.sv
module exlat_wb_pipe
   import exlat_pkg::*;
#(
   parameter  int DW      = 32,
   parameter  int NREG    = 16,
   parameter  int LAT_ALU = 1,
   parameter  int LAT_LD  = 2,
   parameter  int LAT_MUL = 3,
   localparam int AW      = $clog2(NREG)
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          iss_valid,
   input  logic [1:0]    iss_class,
   input  logic [AW-1:0] iss_dest,
   input  logic [DW-1:0] iss_data,
   input  logic          ld_hit,
   input  logic [DW-1:0] ld_data,
   input  logic [AW-1:0] rd_addr_a,
   output logic [DW-1:0] rd_data_a,
   input  logic [AW-1:0] rd_addr_b,
   output logic [DW-1:0] rd_data_b,
   output logic          stall,
   output logic          sched_err
);

   localparam int NC    = NUM_CLASS;
   localparam int LD_IX = int'(OP_LOAD);

   if (!(LAT_ALU >= 1 && LAT_ALU < LAT_LD && LAT_LD < LAT_MUL)) begin : g_bad_order
      $error("exlat_wb_pipe: latencies must rise strictly ALU < LD < MUL, ALU >= 1");
   end
   if (LAT_LD < 2) begin : g_bad_ld
      $error("exlat_wb_pipe: load latency must be at least 2");
   end
   if (NREG < 2 || NREG != (1 << AW)) begin : g_bad_nreg
      $error("exlat_wb_pipe: NREG must be a power of two, at least 2");
   end

   logic [NC-1:0]         hv;
   logic [NC-1:0][AW-1:0] hd;
   logic [NC-1:0][DW-1:0] hx;
   logic                  accept, advance, ld_head, miss_q;
   logic                  wv, clash;
   logic [AW-1:0]         wd;
   logic [DW-1:0]         wx;

   assign accept = iss_valid && !stall;

   for (genvar c = 0; c < NC; c++) begin : g_cls
      localparam int L = class_lat(c, LAT_ALU, LAT_LD, LAT_MUL);
      logic [DW-1:0] line_x;

      exlat_delay_line #(.LAT(L), .AW(AW), .DW(DW)) u_line (
         .clk     (clk),
         .rst     (rst),
         .adv     (advance),
         .in_v    (accept && (iss_class == 2'(c))),
         .in_dest (iss_dest),
         .in_data (iss_data),
         .hd_v    (hv[c]),
         .hd_dest (hd[c]),
         .hd_data (line_x)
      );

      if (c == LD_IX) begin : g_ld_src
         logic [DW-1:0] unused_issue_data;
         assign unused_issue_data = line_x;
         assign hx[c] = ld_data;
      end else begin : g_op_src
         assign hx[c] = line_x;
      end
   end

   // a load owns the commit stage only if no older line is also there
   assign ld_head = hv[LD_IX] && !(|(hv >> (LD_IX + 1)));
   assign stall   = ld_head && (!ld_hit || miss_q);
   assign advance = !(ld_head && !ld_hit);

   exlat_commit_arb #(.NC(NC), .AW(AW), .DW(DW)) u_arb (
      .hv    (hv),
      .hd    (hd),
      .hx    (hx),
      .wv    (wv),
      .wd    (wd),
      .wx    (wx),
      .clash (clash)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         miss_q    <= 1'b0;
         sched_err <= 1'b0;
      end else begin
         sched_err <= sched_err | clash;
         if (ld_head && !ld_hit) miss_q <= 1'b1;
         else if (advance)       miss_q <= 1'b0;
      end
   end

   exlat_regfile #(.NREG(NREG), .AW(AW), .DW(DW)) u_rf (
      .clk (clk),
      .rst (rst),
      .we  (wv && advance),
      .wa  (wd),
      .wd  (wx),
      .ra0 (rd_addr_a),
      .rd0 (rd_data_a),
      .ra1 (rd_addr_b),
      .rd1 (rd_data_b)
   );

endmodule

// File: rtl/exlat_wb_pipe_chk.sv
module exlat_wb_pipe_chk #(
   parameter int DW = 32,
   parameter int AW = 4
) (
   input logic          clk,
   input logic          rst,
   input logic          stall,
   input logic          ld_hit,
   input logic          sched_err,
   input logic [AW-1:0] rd_addr_a,
   input logic [DW-1:0] rd_data_a,
   input logic [AW-1:0] rd_addr_b,
   input logic [DW-1:0] rd_data_b
);

   // R1
   reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> (!stall && !sched_err));

   // R2
   zero_reg_a_chk: assert property (@(posedge clk) disable iff (rst)
      (rd_addr_a == '0) |-> (rd_data_a == '0));

   // R2
   zero_reg_b_chk: assert property (@(posedge clk) disable iff (rst)
      (rd_addr_b == '0) |-> (rd_data_b == '0));

   // R6
   stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (stall && !ld_hit) |=> stall);

   // R6
   stall_release_chk: assert property (@(posedge clk) disable iff (rst)
      (stall && ld_hit) |=> !stall);

   // R7
   frozen_rf_chk: assert property (@(posedge clk) disable iff (rst)
      (stall && !ld_hit) |=> ((rd_addr_a != $past(rd_addr_a)) || (rd_data_a == $past(rd_data_a))));

   // R8
   err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
      sched_err |=> sched_err);

endmodule

bind exlat_wb_pipe exlat_wb_pipe_chk #(.DW(DW), .AW(AW)) u_chk (
   .clk       (clk),
   .rst       (rst),
   .stall     (stall),
   .ld_hit    (ld_hit),
   .sched_err (sched_err),
   .rd_addr_a (rd_addr_a),
   .rd_data_a (rd_data_a),
   .rd_addr_b (rd_addr_b),
   .rd_data_b (rd_data_b)
);

// File: tb/exlat_wb_pipe_bench.sv
module exlat_wb_pipe_bench;

   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        iss_valid = 1'b0;
   logic [1:0]  iss_class = 2'd0;
   logic [3:0]  iss_dest = '0;
   logic [31:0] iss_data = '0;
   logic        ld_hit = 1'b1;
   logic [31:0] ld_data = '0;
   logic [3:0]  rd_addr_a = '0;
   logic [3:0]  rd_addr_b = '0;
   logic [31:0] rd_data_a, rd_data_b;
   logic        stall, sched_err;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   // bench model of the architectural state
   logic [31:0] m_reg [16];
   bit          sv [3];
   int          sc [3];
   int          sd [3];
   logic [31:0] sx [3];
   bit          sk [3];
   bit          miss_m, err_m;

   always #(CLK_PERIOD / 2) clk = ~clk;

   exlat_wb_pipe u_exlat_wb_pipe (
      .clk(clk), .rst(rst), .iss_valid(iss_valid), .iss_class(iss_class),
      .iss_dest(iss_dest), .iss_data(iss_data), .ld_hit(ld_hit), .ld_data(ld_data),
      .rd_addr_a(rd_addr_a), .rd_data_a(rd_data_a), .rd_addr_b(rd_addr_b),
      .rd_data_b(rd_data_b), .stall(stall), .sched_err(sched_err)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [31:0] model_rd(input int a);
      return (a == 0) ? 32'h0 : m_reg[a];
   endfunction

   function automatic int lat_of(input int cls);
      return (cls == 0) ? 1 : (cls == 1) ? 2 : 3;
   endfunction

   task automatic model_clear();
      for (int i = 0; i < 16; i++) m_reg[i] = '0;
      for (int k = 0; k < 3; k++) begin
         sv[k] = 0; sk[k] = 0; sc[k] = 0; sd[k] = 0; sx[k] = '0;
      end
      miss_m = 0;
      err_m  = 0;
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1;
      iss_valid = 1'b0;
      ld_hit = 1'b1;
      repeat (2) @(posedge clk);
      model_clear();
      @(negedge clk);
      rst = 1'b0;
   endtask

   // one cycle: drive at negedge, sample before the next rising edge, update model
   task automatic step(input bit v, input int cls, input int dest, input logic [31:0] dat,
                       input bit hit, input logic [31:0] ldd, input int ra, input int rb,
                       input string tag, input bit ck = 1'b0, input logic [31:0] ea = '0);
      bit ldh, stall_e, adv_e, acc;
      int idx;
      @(negedge clk);
      iss_valid = v;
      iss_class = 2'(cls);
      iss_dest  = 4'(dest);
      iss_data  = dat;
      ld_hit    = hit;
      ld_data   = ldd;
      rd_addr_a = 4'(ra);
      rd_addr_b = 4'(rb);
      #1;
      ldh     = sv[0] && (sc[0] == 1);
      stall_e = ldh && (!hit || miss_m);
      adv_e   = !(ldh && !hit);
      chk("R6 stall", {31'b0, stall}, {31'b0, stall_e});
      chk(tag, rd_data_a, model_rd(ra));
      chk(tag, rd_data_b, model_rd(rb));
      if (ck) chk(tag, rd_data_a, ea);
      @(posedge clk);
      acc = v && !stall_e && (cls != 3);
      if (acc) begin
         idx = lat_of(cls) - 1;
         if (sv[idx]) sk[idx] = 1;
         else begin
            sv[idx] = 1; sc[idx] = cls; sd[idx] = dest; sx[idx] = dat; sk[idx] = 0;
         end
      end
      if (sv[0] && sk[0]) err_m = 1;
      if (adv_e) begin
         if (sv[0] && sd[0] != 0) m_reg[sd[0]] = (sc[0] == 1) ? ldd : sx[0];
         for (int k = 0; k < 2; k++) begin
            sv[k] = sv[k+1]; sc[k] = sc[k+1]; sd[k] = sd[k+1]; sx[k] = sx[k+1]; sk[k] = sk[k+1];
         end
         sv[2] = 0; sk[2] = 0;
         miss_m = 0;
      end else begin
         miss_m = 1;
      end
      #1;
      chk("R8 sched_err", {31'b0, sched_err}, {31'b0, err_m});
   endtask

   task automatic idle(input int ra, input int rb, input string tag,
                       input bit ck = 1'b0, input logic [31:0] ea = '0);
      step(0, 0, 0, '0, 1, '0, ra, rb, tag, ck, ea);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_fail++;
         n_chk++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h5eed1234));
      model_clear();
      do_reset();

      // R1: everything cleared after reset
      chk("R1 stall", {31'b0, stall}, 32'h0);
      chk("R1 err", {31'b0, sched_err}, 32'h0);
      for (int i = 0; i < 16; i++) idle(i, 15 - i, "R1 reg", 1'b1, 32'h0);

      // R2: writes to register 0 are dropped
      step(1, 0, 0, 32'hDEAD_BEEF, 1, '0, 0, 0, "R2");
      idle(0, 0, "R2 zero", 1'b1, 32'h0);

      // R3: ALU result visible the next cycle, not in the issue cycle
      step(1, 0, 5, 32'h1111_1111, 1, '0, 5, 0, "R3 same", 1'b1, 32'h0);
      idle(5, 0, "R3 next", 1'b1, 32'h1111_1111);

      // R4: multiply keeps old contents for two cycles
      step(1, 2, 6, 32'h2222_2222, 1, '0, 6, 0, "R4 t", 1'b1, 32'h0);
      idle(6, 0, "R4 t1", 1'b1, 32'h0);
      idle(6, 0, "R4 t2", 1'b1, 32'h0);
      idle(6, 0, "R4 t3", 1'b1, 32'h2222_2222);

      // R5: load hit; issue data ignored, completion data committed
      step(1, 1, 7, 32'h0BAD_0BAD, 1, '0, 7, 0, "R5 t", 1'b1, 32'h0);
      step(0, 0, 0, '0, 1, 32'h3333_3333, 7, 0, "R5 t1", 1'b1, 32'h0);
      idle(7, 0, "R5 t2", 1'b1, 32'h3333_3333);

      // R6 / R7: miss stalls, offered issues are dropped, new value after
      step(1, 1, 8, 32'h0, 1, '0, 8, 9, "R6 t");
      step(1, 0, 9, 32'h9999_9999, 0, 32'hFFFF_0000, 8, 9, "R7 blocked", 1'b1, 32'h0);
      step(1, 2, 9, 32'h8888_8888, 0, 32'hFFFF_0001, 8, 9, "R7 blocked", 1'b1, 32'h0);
      step(1, 0, 9, 32'h7777_7777, 1, 32'h4444_4444, 8, 9, "R6 return", 1'b1, 32'h0);
      idle(8, 9, "R6 after", 1'b1, 32'h4444_4444);
      idle(9, 8, "R7 r9", 1'b1, 32'h0);
      idle(9, 8, "R7 r9", 1'b1, 32'h0);
      idle(9, 8, "R7 r9", 1'b1, 32'h0);

      // R8: multiply and later ALU meet at commit; older wins, flag set
      step(1, 2, 10, 32'hAAAA_AAAA, 1, '0, 10, 0, "R8");
      idle(10, 0, "R8");
      step(1, 0, 10, 32'h5555_5555, 1, '0, 10, 0, "R8");
      idle(10, 0, "R8 winner", 1'b1, 32'hAAAA_AAAA);
      chk("R8 flag", {31'b0, sched_err}, 32'h1);

      // R8: multiply beats a later load; no stall despite a low hit flag
      step(1, 2, 12, 32'hCCCC_CCCC, 1, '0, 12, 0, "R8");
      step(1, 1, 12, 32'h0, 1, '0, 12, 0, "R8");
      step(0, 0, 0, '0, 0, 32'hEEEE_EEEE, 12, 0, "R8 no stall");
      idle(12, 0, "R8 mul kept", 1'b1, 32'hCCCC_CCCC);

      // R9: class code 3 never writes
      step(1, 3, 11, 32'h7777_0000, 1, '0, 11, 0, "R9");
      idle(11, 0, "R9", 1'b1, 32'h0);
      idle(11, 0, "R9", 1'b1, 32'h0);
      idle(11, 0, "R9", 1'b1, 32'h0);

      // R10: two ports, different registers, same cycle
      idle(5, 6, "R10 a", 1'b1, 32'h1111_1111);
      idle(6, 5, "R10 a", 1'b1, 32'h2222_2222);

      // R1: reset clears the sticky flag and registers
      do_reset();
      chk("R1 err cleared", {31'b0, sched_err}, 32'h0);
      idle(5, 6, "R1 cleared", 1'b1, 32'h0);

      // random traffic checked against the model
      for (int n = 0; n < 3000; n++) begin
         bit v;
         bit h;
         v = ($urandom % 10) < 6;
         h = ($urandom % 4) != 0;
         step(v, int'($urandom % 4), int'($urandom % 16), $urandom, h, $urandom,
              int'($urandom % 16), int'($urandom % 16), "R10 random");
      end

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule